// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register of an out-of-order core, the committed register value and a pending-writer record: either blank, or the tag of the reservation station that will produce the next value. At issue, an instruction presents two source register numbers and, optionally, a destination. For each source the table answers with a ready value or with the tag of the producer to wait on. The destination is then renamed to the tag of the station that the instruction was allocated.

A result bus carries a tag and a data word. Every register whose pending writer equals that tag takes the data and goes back to blank. A register that has been renamed again since the broadcasting instruction issued no longer holds that tag, so a late result from an older writer is dropped. This settles write-after-write ordering without any compare against program order. Lookup results are registered and appear one clock after the issue request.

Top module: `rename_table`

## Requirements
- R1: After synchronous reset every register is blank with value zero, and all outputs are zero; a first lookup of any register returns ready with value 0.
- R2: An issue with `iss_valid`=1 and `iss_dst_we`=1 records `iss_tag` as the pending writer of `iss_dst`; a later lookup of that register returns `*_ready`=0, `*_tag` equal to that tag and `*_value`=0 (tag value 0 is a legal station).
- R3: A lookup of a blank register returns `*_ready`=1, the stored value on `*_value` and `*_tag`=0.
- R4: A broadcast whose tag equals a register's pending writer stores the broadcast data in that register and makes it blank.
- R5: A broadcast whose tag differs from a register's pending writer leaves that register's value and pending writer unchanged.
- R6: When a lookup and a broadcast matching the source's pending writer occur in the same cycle, the lookup returns ready with the broadcast data.
- R7: When an issue renames a register in the same cycle that a matching broadcast completes it, the register keeps the new tag as pending writer.
- R8: A lookup whose source equals the same cycle's destination returns the mapping held before that issue.
- R9: `out_valid` equals `iss_valid` of the previous cycle; the lookup outputs change only one cycle after an issue and hold otherwise.
- R10: With `iss_valid`=0 or `iss_dst_we`=0 no register is renamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_src_a | input | 4 | First source register number |
| iss_src_b | input | 4 | Second source register number |
| iss_dst_we | input | 1 | Issuing instruction writes a register |
| iss_dst | input | 4 | Destination register number |
| iss_tag | input | 4 | Station tag allocated to the issuing instruction |
| cdb_valid | input | 1 | Result broadcast this cycle |
| cdb_tag | input | 4 | Tag of the station that produced the result |
| cdb_data | input | 32 | Result value |
| out_valid | output | 1 | Lookup outputs belong to the previous cycle's issue |
| a_ready | output | 1 | First source value is available |
| a_value | output | 32 | First source value (0 when waiting) |
| a_tag | output | 4 | First source producer tag (0 when ready) |
| b_ready | output | 1 | Second source value is available |
| b_value | output | 32 | Second source value (0 when waiting) |
| b_tag | output | 4 | Second source producer tag (0 when ready) |

## Verification
The functions that collide are issue and result broadcast: a lookup can meet a broadcast for the very register it reads, and a rename can meet a broadcast completing the same register. Directed cycles drive both ports at once on one register, and a random phase picks broadcast tags mostly from the writers currently pending so such overlaps happen often. A behavioural model of the table steps each cycle with lookup taken before the broadcast and rename updates, and every output is compared with it one cycle after the request.

// File: rtl/rt_pkg.sv
package rt_pkg;
  // Where a source operand is taken from during a lookup
  typedef enum logic [1:0] {
    SRC_FILE = 2'd0,
    SRC_FWD  = 2'd1,
    SRC_WAIT = 2'd2
  } src_kind_e;
endpackage

// File: rtl/rt_status.sv
module rt_status #(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            iss_we,
  input  logic [REG_W-1:0]                iss_dst,
  input  logic [TAG_W-1:0]                iss_tag,
  input  logic                            cdb_valid,
  input  logic [TAG_W-1:0]                cdb_tag,
  output logic [NUM_REGS-1:0]             busy_q,
  output logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q,
  output logic [NUM_REGS-1:0]             hit
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic ren;
    assign hit[i] = cdb_valid && busy_q[i] && (tag_q[i] == cdb_tag);
    assign ren    = iss_we && (iss_dst == REG_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q[i] <= 1'b0;
        tag_q[i]  <= '0;
      end else if (ren) begin
        busy_q[i] <= 1'b1;
        tag_q[i]  <= iss_tag;
      end else if (hit[i]) begin
        busy_q[i] <= 1'b0;
      end
    end

    // R2 R7
    rename_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (iss_we && iss_dst == REG_W'(i)) |=> (busy_q[i] && tag_q[i] == $past(iss_tag)));

    // R5
    stale_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q[i] && !(cdb_valid && cdb_tag == tag_q[i]) && !(iss_we && iss_dst == REG_W'(i)))
      |=> (busy_q[i] && $stable(tag_q[i])));

    // R4
    commit_blank_chk: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && busy_q[i] && cdb_tag == tag_q[i] && !(iss_we && iss_dst == REG_W'(i)))
      |=> !busy_q[i]);

    // R10
    no_rename_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_q[i] && !(iss_we && iss_dst == REG_W'(i))) |=> !busy_q[i]);
  end

endmodule

// File: rtl/rt_regfile.sv
module rt_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_RD   = 2,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_REGS-1:0]               wr_mask,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [NUM_RD-1:0][REG_W-1:0]      rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0]     rd_data
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)             mem[i] <= '0;
      else if (wr_mask[i]) mem[i] <= wr_data;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_data[r] = mem[rd_addr[r]];
  end

endmodule

// File: rtl/rt_lookup.sv
module rt_lookup
  import rt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            valid,
  input  logic [REG_W-1:0]                src,
  input  logic [NUM_REGS-1:0]             busy_vec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_arr,
  input  logic [DATA_W-1:0]               file_data,
  input  logic                            cdb_valid,
  input  logic [TAG_W-1:0]                cdb_tag,
  input  logic [DATA_W-1:0]               cdb_data,
  output logic                            ready_q,
  output logic [DATA_W-1:0]               value_q,
  output logic [TAG_W-1:0]                tag_q
);

  src_kind_e kind;

  always_comb begin
    if (!busy_vec[src])                                kind = SRC_FILE;
    else if (cdb_valid && cdb_tag == tag_arr[src])     kind = SRC_FWD;
    else                                               kind = SRC_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      value_q <= '0;
      tag_q   <= '0;
    end else if (valid) begin
      case (kind)
        SRC_FILE: begin ready_q <= 1'b1; value_q <= file_data; tag_q <= '0; end
        SRC_FWD:  begin ready_q <= 1'b1; value_q <= cdb_data;  tag_q <= '0; end
        default:  begin ready_q <= 1'b0; value_q <= '0;        tag_q <= tag_arr[src]; end
      endcase
    end
  end

  // R3
  file_path_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !busy_vec[src]) |=> (ready_q && value_q == $past(file_data)));

  // R6
  fwd_path_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && busy_vec[src] && cdb_valid && cdb_tag == tag_arr[src])
    |=> (ready_q && value_q == $past(cdb_data)));

  // R2
  wait_path_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && busy_vec[src] && !(cdb_valid && cdb_tag == tag_arr[src]))
    |=> (!ready_q && tag_q == $past(tag_arr[src])));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(ready_q) && $stable(value_q) && $stable(tag_q)));

endmodule

// File: rtl/rename_table.sv
module rename_table #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [REG_W-1:0]  iss_src_a,
  input  logic [REG_W-1:0]  iss_src_b,
  input  logic              iss_dst_we,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              out_valid,
  output logic              a_ready,
  output logic [DATA_W-1:0] a_value,
  output logic [TAG_W-1:0]  a_tag,
  output logic              b_ready,
  output logic [DATA_W-1:0] b_value,
  output logic [TAG_W-1:0]  b_tag
);

  localparam int NUM_SRC = 2;

  logic                           iss_we;
  logic [NUM_REGS-1:0]            busy_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0] tag_arr;
  logic [NUM_REGS-1:0]            hit_vec;
  logic [NUM_SRC-1:0][REG_W-1:0]  src_addr;
  logic [NUM_SRC-1:0][DATA_W-1:0] file_data;
  logic [NUM_SRC-1:0]             rdy;
  logic [NUM_SRC-1:0][DATA_W-1:0] val;
  logic [NUM_SRC-1:0][TAG_W-1:0]  tg;

  assign iss_we   = iss_valid && iss_dst_we;
  assign src_addr = {iss_src_b, iss_src_a};

  rt_status #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .iss_we    (iss_we),
    .iss_dst   (iss_dst),
    .iss_tag   (iss_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .busy_q    (busy_vec),
    .tag_q     (tag_arr),
    .hit       (hit_vec)
  );

  rt_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_SRC)) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (hit_vec),
    .wr_data (cdb_data),
    .rd_addr (src_addr),
    .rd_data (file_data)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rt_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_lookup (
      .clk       (clk),
      .rst       (rst),
      .valid     (iss_valid),
      .src       (src_addr[s]),
      .busy_vec  (busy_vec),
      .tag_arr   (tag_arr),
      .file_data (file_data[s]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_data  (cdb_data),
      .ready_q   (rdy[s]),
      .value_q   (val[s]),
      .tag_q     (tg[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= iss_valid;
  end

  assign a_ready = rdy[0];
  assign a_value = val[0];
  assign a_tag   = tg[0];
  assign b_ready = rdy[1];
  assign b_value = val[1];
  assign b_tag   = tg[1];

  // R9
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> out_valid);

  // R9
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> !out_valid);

endmodule

// File: tb/rename_table_bench.sv
module rename_table_bench;
  localparam int NR = 16;
  localparam int DW = 32;
  localparam int TW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic iss_valid, iss_dst_we, cdb_valid;
  logic [3:0] iss_src_a, iss_src_b, iss_dst;
  logic [TW-1:0] iss_tag, cdb_tag;
  logic [DW-1:0] cdb_data;
  logic out_valid, a_ready, b_ready;
  logic [DW-1:0] a_value, b_value;
  logic [TW-1:0] a_tag, b_tag;

  rename_table u_rename_table (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst_we(iss_dst_we), .iss_dst(iss_dst),
    .iss_tag(iss_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .out_valid(out_valid), .a_ready(a_ready),
    .a_value(a_value), .a_tag(a_tag), .b_ready(b_ready), .b_value(b_value),
    .b_tag(b_tag)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model
  bit            m_busy [NR];
  logic [TW-1:0] m_tag  [NR];
  logic [DW-1:0] m_val  [NR];
  logic          e_ov, e_ar, e_br;
  logic [DW-1:0] e_av, e_bv;
  logic [TW-1:0] e_at, e_bt;
  string         lbl_a, lbl_b, cur_req;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req == "" ? "R9" : cur_req, "out_valid", DW'(out_valid), DW'(e_ov));
    chk(lbl_a, "a_ready", DW'(a_ready), DW'(e_ar));
    chk(lbl_a, "a_value", a_value, e_av);
    chk(lbl_a, "a_tag",   DW'(a_tag), DW'(e_at));
    chk(lbl_b, "b_ready", DW'(b_ready), DW'(e_br));
    chk(lbl_b, "b_value", b_value, e_bv);
    chk(lbl_b, "b_tag",   DW'(b_tag), DW'(e_bt));
  endtask

  task automatic model_src(input int s, input logic cv, input logic [TW-1:0] ct,
                           input logic [DW-1:0] cd, output logic r,
                           output logic [DW-1:0] v, output logic [TW-1:0] t,
                           output string l);
    if (!m_busy[s])             begin r = 1; v = m_val[s]; t = '0; l = "R3"; end
    else if (cv && ct == m_tag[s]) begin r = 1; v = cd;    t = '0; l = "R6"; end
    else                        begin r = 0; v = '0; t = m_tag[s];  l = "R2"; end
    if (cur_req != "") l = cur_req;
  endtask

  task automatic step(input logic iv, input int sa, input int sb, input logic we,
                      input int d, input int t, input logic cv, input int ct,
                      input logic [DW-1:0] cd);
    logic ra, rb;
    logic [DW-1:0] va, vb;
    logic [TW-1:0] ta, tb;
    string la, lb;
    @(negedge clk);
    compare();
    iss_valid = iv; iss_src_a = 4'(sa); iss_src_b = 4'(sb);
    iss_dst_we = we; iss_dst = 4'(d); iss_tag = TW'(t);
    cdb_valid = cv; cdb_tag = TW'(ct); cdb_data = cd;
    model_src(sa, cv, TW'(ct), cd, ra, va, ta, la);
    model_src(sb, cv, TW'(ct), cd, rb, vb, tb, lb);
    e_ov = iv;
    if (iv) begin
      e_ar = ra; e_av = va; e_at = ta; lbl_a = la;
      e_br = rb; e_bv = vb; e_bt = tb; lbl_b = lb;
    end else begin
      lbl_a = (cur_req == "") ? "R9" : cur_req;
      lbl_b = lbl_a;
    end
    for (int r = 0; r < NR; r++)
      if (cv && m_busy[r] && m_tag[r] == TW'(ct)) begin
        m_val[r] = cd; m_busy[r] = 0;
      end
    if (iv && we) begin m_busy[d] = 1; m_tag[d] = TW'(t); end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1; iss_valid = 0; iss_src_a = 0; iss_src_b = 0; iss_dst_we = 0;
    iss_dst = 0; iss_tag = 0; cdb_valid = 0; cdb_tag = 0; cdb_data = 0;
    for (int r = 0; r < NR; r++) begin m_busy[r] = 0; m_tag[r] = 0; m_val[r] = 0; end
    e_ov = 0; e_ar = 0; e_av = 0; e_at = 0; e_br = 0; e_bv = 0; e_bt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cur_req = "R1"; lbl_a = "R1"; lbl_b = "R1";
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);           // reset outputs still zero
    step(1, 0, 15, 0, 0, 0, 0, 0, 0);          // first lookup: ready, 0
    cur_req = "R2";
    step(1, 1, 2, 1, 3, 7, 0, 0, 0);
    step(1, 4, 1, 1, 4, 0, 0, 0, 0);
    step(1, 3, 4, 0, 0, 0, 0, 0, 0);           // pending 7 and pending 0
    cur_req = "R4";
    step(1, 3, 3, 0, 0, 0, 1, 7, 32'hAAAA_0001);
    step(1, 3, 4, 0, 0, 0, 0, 0, 0);           // 3 now holds data
    cur_req = "R5";
    step(1, 0, 0, 1, 5, 2, 0, 0, 0);
    step(1, 0, 0, 1, 5, 9, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 1, 2, 32'h1111_1111); // stale tag 2
    step(1, 5, 3, 0, 0, 0, 0, 0, 0);           // still waits on 9
    step(1, 2, 2, 0, 0, 0, 1, 9, 32'h2222_2222);
    step(1, 5, 5, 0, 0, 0, 0, 0, 0);
    cur_req = "R6";
    step(1, 0, 0, 1, 6, 1, 0, 0, 0);
    step(1, 6, 2, 0, 0, 0, 1, 1, 32'h3333_3333);
    step(1, 6, 6, 0, 0, 0, 0, 0, 0);
    cur_req = "R7";
    step(1, 0, 0, 1, 7, 3, 0, 0, 0);
    step(1, 0, 0, 1, 7, 4, 1, 3, 32'h4444_4444);
    step(1, 7, 7, 0, 0, 0, 0, 0, 0);           // waits on 4
    step(1, 7, 0, 0, 0, 0, 1, 4, 32'h5555_5555);
    step(1, 7, 7, 0, 0, 0, 0, 0, 0);
    cur_req = "R8";
    step(1, 8, 3, 1, 8, 5, 0, 0, 0);           // reads value before rename
    step(1, 8, 8, 0, 0, 0, 0, 0, 0);
    cur_req = "R10";
    step(1, 0, 0, 0, 9, 6, 0, 0, 0);
    step(0, 0, 0, 1, 10, 6, 0, 0, 0);
    step(1, 9, 10, 0, 0, 0, 0, 0, 0);
    cur_req = "R9";
    step(0, 8, 8, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 1, 5, 32'h6666_6666);
    step(1, 8, 9, 0, 0, 0, 0, 0, 0);
    cur_req = "";
    for (int k = 0; k < 3000; k++) begin
      int r;
      int ct;
      r  = $urandom_range(0, NR - 1);
      ct = m_busy[r] ? int'(m_tag[r]) : $urandom_range(0, 15);
      step($urandom_range(0, 3) != 0, $urandom_range(0, NR - 1), $urandom_range(0, NR - 1),
           $urandom_range(0, 1), $urandom_range(0, NR - 1), $urandom_range(0, 15),
           $urandom_range(0, 1), ct, $urandom);
    end
    @(negedge clk);
    compare();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule